// File: doc/BRIEF.md
# Heartbeat Collision Test Monitor

This block checks that a transceiver returns its heartbeat pulse on the collision-indicator line once each frame transmission is over. A frame ends on the falling edge of the transmit-active signal. From that edge the monitor opens a window and counts bit times. It counts only the cycles in which the bit-rate clock enable is high. If the collision indicator is not seen before the window has run for `WINDOW_BITS` bit times (40 by default), a sticky collision-error flag is raised.

When the twisted-pair port is selected, the heartbeat window is not used. The monitor instead samples the link-fail status at the end of each frame and raises the same flag if the link is down.

Any rise of the collision-error flag also raises a sticky summary error flag. The host clears each flag with a write-one-to-clear strobe and a two-bit mask. The block has no interrupt output, so the collision error can never cause an interrupt.

Top module: `hb_sqe_monitor`

## Requirements
- R1: After reset both `coll_err` and `sum_err` read 0.
- R2: In window mode (`tp_sel` = 0 at the end of a frame), the flags are visible one clock after the edge that samples the enable completing the window. The enable counts if the collision indicator stays low in every cycle from the cycle in which `tx_active` is first seen low up to the end of the window. The window is `WINDOW_BITS` cycles with `bit_en` high, counted after that cycle.
- R3: A collision-indicator cycle anywhere in the window ends the check for that frame with no error. This includes the cycle that carries the last counted bit enable.
- R4: Cycles with `bit_en` low do not advance the window. Any number of them leaves the flags at 0, and fewer than `WINDOW_BITS` bit enables never raise an error.
- R5: Once the heartbeat is seen, the rest of the idle time is ignored until the next frame ends. No error is raised however many bit enables follow.
- R6: If `tx_active` rises again before the window expires, the pending check is dropped without an error. Bit enables during that transmission are not counted, and the next frame end starts a fresh window.
- R7: In twisted-pair mode (`tp_sel` = 1 at the end of a frame) with `link_fail` = 0, no error is raised, whatever the collision indicator and bit enables do.
- R8: In twisted-pair mode with `link_fail` = 1 in the cycle `tx_active` is first seen low, both flags read 1 one clock after that cycle's edge.
- R9: Every setting of `coll_err` also sets `sum_err`.
- R10: The flags are sticky. A cycle with `clr_stb` = 1 clears `coll_err` if `clr_mask[0]` = 1 and `sum_err` if `clr_mask[1]` = 1, starting on the next clock. A flag whose mask bit is 0 is left unchanged.
- R11: If an error is being set in the same cycle as a clear of that flag, the flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle enable per network bit time |
| tx_active | input | 1 | High while a frame is being transmitted |
| coll_in | input | 1 | Collision indicator from the transceiver |
| tp_sel | input | 1 | 1 selects the twisted-pair port (link test instead of window) |
| link_fail | input | 1 | Twisted-pair link is in the fail state |
| clr_stb | input | 1 | Host write strobe for flag clearing |
| clr_mask | input | 2 | Write-one-to-clear bits: [0] collision error, [1] summary error |
| coll_err | output | 1 | Sticky collision-error flag |
| sum_err | output | 1 | Sticky summary error flag |

## Verification
The bench targets the off-by-one edges of the window:
- 39 bit enables must leave the flags clear and the 40th must set them. A counter that starts one early or one late fails one of the two checks.
- A heartbeat arriving in the same cycle as the 40th enable must win over the timeout.
- A long stretch with no bit enables exposes a counter that counts clocks instead of bit times.

Aborting a window with a new transmission checks two faults. A design that forgets to drop the pending check would flag an error, and one that keeps its old count would fire too early on the following frame.

The bench also covers:
- twisted-pair mode with the link up and with the link down;
- clearing one flag while the other stays set;
- a clear that coincides with a new error, where a design that gives the clear priority would read back 0.

// File: rtl/hb_pkg.sv
// Package: hb_pkg
// Shared types for the heartbeat collision test monitor.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package hb_pkg;

    // Window state: idle between checks, or counting bit times after a frame
    typedef enum logic {
        HB_IDLE = 1'b0,
        HB_WAIT = 1'b1
    } hb_state_t;

    // Flag indices, shared by the clear mask and the flag bank
    localparam int HB_FLAG_COLL = 0;
    localparam int HB_FLAG_SUM  = 1;
    localparam int HB_NUM_FLAGS = 2;

endpackage

// File: rtl/hb_tx_edge.sv
// Module: hb_tx_edge
// Detects the end of a frame: the first cycle in which tx_active is low
// after being high. Output is combinational from the registered history.
// Assumes: tx_active is synchronous to clk.
module hb_tx_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_active,
    output logic tx_fall
);

    logic tx_q;

    // Remember last cycle's transmit-active level
    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= 1'b0;
        else        tx_q <= tx_active;
    end

    // End of frame: was high, now low
    always_comb begin
        tx_fall = tx_q & ~tx_active;
    end

endmodule

// File: rtl/hb_window_fsm.sv
// Module: hb_window_fsm
// At each frame end, either tests link_fail (twisted-pair mode) or opens a
// window of WINDOW_BITS bit times that the collision indicator must hit.
// err_set is a one-cycle combinational request to raise the error flags.
// Assumes: bit_en is a single-cycle pulse per bit time; tp_sel is sampled
// only at the frame end.
module hb_window_fsm
    import hb_pkg::*;
#(
    parameter int WINDOW_BITS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic tx_fall,
    input  logic tx_active,
    input  logic coll_in,
    input  logic tp_sel,
    input  logic link_fail,
    output logic err_set,
    output logic win_active
);

    localparam int CW = (WINDOW_BITS > 1) ? $clog2(WINDOW_BITS) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(WINDOW_BITS - 1);

    hb_state_t      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // Next-state, counter and error request decode
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        err_set = 1'b0;
        unique case (state_q)
            HB_IDLE: begin
                if (tx_fall) begin
                    if (tp_sel) begin
                        err_set = link_fail;
                    end else if (!coll_in) begin
                        state_d = HB_WAIT;
                        cnt_d   = '0;
                    end
                end
            end
            HB_WAIT: begin
                if (tx_active) begin
                    state_d = HB_IDLE;
                end else if (coll_in) begin
                    state_d = HB_IDLE;
                end else if (bit_en) begin
                    if (cnt_q == LAST_BIT) begin
                        err_set = 1'b1;
                        state_d = HB_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: state_d = HB_IDLE;
        endcase
    end

    // State and bit-time counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HB_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Window-open indication for the flag logic's checker
    always_comb begin
        win_active = (state_q == HB_WAIT);
    end

endmodule

// File: rtl/hb_w1c_flag.sv
// Module: hb_w1c_flag
// One sticky status bit with write-one-to-clear; a set in the same cycle
// as a clear wins.
// Assumes: set and clr are synchronous single-cycle requests.
module hb_w1c_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);

    // Sticky bit update with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end

endmodule

// File: rtl/hb_sqe_monitor.sv
// Module: hb_sqe_monitor (top)
// Post-transmit heartbeat monitor: frame-end detector, window FSM and a
// bank of write-one-to-clear flags (collision error, summary error).
// Assumes: all inputs synchronous to clk; no interrupt is produced.
module hb_sqe_monitor
    import hb_pkg::*;
#(
    parameter int WINDOW_BITS = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       tx_active,
    input  logic       coll_in,
    input  logic       tp_sel,
    input  logic       link_fail,
    input  logic       clr_stb,
    input  logic [1:0] clr_mask,
    output logic       coll_err,
    output logic       sum_err
);

    logic                    tx_fall;
    logic                    coll_set;
    logic                    win_active;
    logic [HB_NUM_FLAGS-1:0] flag_set;
    logic [HB_NUM_FLAGS-1:0] flag_clr;
    logic [HB_NUM_FLAGS-1:0] flag_q;

    hb_tx_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_active (tx_active),
        .tx_fall   (tx_fall)
    );

    hb_window_fsm #(
        .WINDOW_BITS (WINDOW_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .tx_fall    (tx_fall),
        .tx_active  (tx_active),
        .coll_in    (coll_in),
        .tp_sel     (tp_sel),
        .link_fail  (link_fail),
        .err_set    (coll_set),
        .win_active (win_active)
    );

    // Route the error request to both flags and gate the host clear mask
    always_comb begin
        flag_set               = '0;
        flag_set[HB_FLAG_COLL] = coll_set;
        flag_set[HB_FLAG_SUM]  = coll_set;
        flag_clr               = clr_stb ? clr_mask : '0;
    end

    for (genvar g = 0; g < HB_NUM_FLAGS; g++) begin : g_flag
        hb_w1c_flag u_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (flag_set[g]),
            .clr   (flag_clr[g]),
            .q     (flag_q[g])
        );
    end

    assign coll_err = flag_q[HB_FLAG_COLL];
    assign sum_err  = flag_q[HB_FLAG_SUM];

endmodule

// File: rtl/hb_sqe_checker.sv
// Module: hb_sqe_checker
// Assertion checker bound into hb_sqe_monitor. Keeps its own count of bit
// enables while the window is open, independent of the FSM counter.
module hb_sqe_checker #(
    parameter int WINDOW_BITS = 40
) (
    input logic       clk,
    input logic       rst_n,
    input logic       bit_en,
    input logic       tx_active,
    input logic       coll_in,
    input logic       clr_stb,
    input logic [1:0] clr_mask,
    input logic       coll_set,
    input logic       win_active,
    input logic       coll_err,
    input logic       sum_err
);

    localparam int KW = $clog2(WINDOW_BITS + 1) + 1;
    localparam logic [KW-1:0] K_LAST = KW'(WINDOW_BITS - 1);

    logic [KW-1:0] seen_q;

    // Independent bit-time tally while the window is open
    always_ff @(posedge clk) begin
        if (!rst_n || !win_active) seen_q <= '0;
        else if (bit_en && seen_q != '1) seen_q <= seen_q + 1'b1;
    end

    // R2: timeout in window mode raises the collision error next cycle
    assert_timeout_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && bit_en && !coll_in && !tx_active && seen_q == K_LAST) |=> coll_err);

    // R4: an error from the window never comes before the last bit enable
    assert_no_early_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_set && win_active) |-> (bit_en && seen_q == K_LAST));

    // R6: a transmission in progress never produces an error request
    assert_abort_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_active |-> !coll_set);

    // R9: the summary flag accompanies any rise of the collision flag
    assert_sum_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(coll_err) |-> sum_err);

    // R10: collision flag holds unless cleared
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (coll_err && !(clr_stb && clr_mask[0])) |=> coll_err);

    // R10: clear without a coincident set drops the summary flag
    assert_clear_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && clr_mask[1] && !coll_set) |=> !sum_err);

    // R11: a set beats a simultaneous clear
    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        coll_set |=> (coll_err && sum_err));

endmodule

bind hb_sqe_monitor hb_sqe_checker #(
    .WINDOW_BITS (WINDOW_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en     (bit_en),
    .tx_active  (tx_active),
    .coll_in    (coll_in),
    .clr_stb    (clr_stb),
    .clr_mask   (clr_mask),
    .coll_set   (coll_set),
    .win_active (win_active),
    .coll_err   (coll_err),
    .sum_err    (sum_err)
);

// File: tb/sim_hb_sqe_monitor.sv
// Scoreboard bench: the driver pushes expected flag pairs, a monitor on the
// falling clock edge pops and compares them against the outputs.
module sim_hb_sqe_monitor;

    localparam int WIN = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       tx_active = 1'b0;
    logic       coll_in = 1'b0;
    logic       tp_sel = 1'b0;
    logic       link_fail = 1'b0;
    logic       clr_stb = 1'b0;
    logic [1:0] clr_mask = 2'b00;
    logic       coll_err;
    logic       sum_err;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [1:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    hb_sqe_monitor #(.WINDOW_BITS(WIN)) u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_active(tx_active),
        .coll_in(coll_in), .tp_sel(tp_sel), .link_fail(link_fail),
        .clr_stb(clr_stb), .clr_mask(clr_mask),
        .coll_err(coll_err), .sum_err(sum_err)
    );

    // Monitor: compare one expected item per falling edge
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_vec++;
            if ({coll_err, sum_err} !== e) begin
                n_bad++;
                $display("FAIL %s: actual coll=%b sum=%b expected coll=%b sum=%b",
                         t, coll_err, sum_err, e[1], e[0]);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic expect_flags(input logic c, input logic s, input string t);
        exp_q.push_back({c, s});
        tag_q.push_back(t);
        wait (exp_q.size() == 0);
    endtask

    task automatic frame(input int len);
        tx_active = 1'b1;
        repeat (len) tick();
        tx_active = 1'b0;
        tick();
    endtask

    task automatic bits(input int n);
        for (int i = 0; i < n; i++) begin
            bit_en = 1'b1; tick();
            bit_en = 1'b0; tick();
        end
    endtask

    task automatic clear(input logic [1:0] m);
        clr_stb = 1'b1; clr_mask = m; tick();
        clr_stb = 1'b0; clr_mask = 2'b00;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        expect_flags(0, 0, "R1 reset state");

        // Plain timeout: 39 enables quiet, 40th sets both
        frame(5);
        bits(WIN - 1);
        expect_flags(0, 0, "R4 no error before last bit");
        bits(1);
        expect_flags(1, 1, "R2 timeout sets error");
        expect_flags(1, 1, "R9 summary set with collision error");
        bits(20);
        expect_flags(1, 1, "R10 flags sticky");
        clear(2'b01);
        expect_flags(0, 1, "R10 clear collision only");
        clear(2'b10);
        expect_flags(0, 0, "R10 clear summary");

        // Heartbeat early, then ignored remainder
        frame(8);
        bits(10);
        coll_in = 1'b1; tick(); coll_in = 1'b0;
        bits(60);
        expect_flags(0, 0, "R5 heartbeat ends check");

        // Heartbeat coinciding with the last bit enable
        frame(3);
        bits(WIN - 1);
        coll_in = 1'b1; bit_en = 1'b1; tick();
        coll_in = 1'b0; bit_en = 1'b0; tick();
        expect_flags(0, 0, "R3 heartbeat on last bit");
        bits(10);
        expect_flags(0, 0, "R3 no late error");

        // Stalled bit clock
        frame(4);
        repeat (300) tick();
        expect_flags(0, 0, "R4 idle cycles do not count");
        bits(WIN);
        expect_flags(1, 1, "R4 timeout after stall");
        clear(2'b11);
        expect_flags(0, 0, "R10 clear both");

        // Abort by a new transmission
        frame(4);
        bits(30);
        tx_active = 1'b1;
        bits(20);
        expect_flags(0, 0, "R6 abort no error");
        tx_active = 1'b0; tick();
        bits(WIN - 1);
        expect_flags(0, 0, "R6 fresh window not early");
        bits(1);
        expect_flags(1, 1, "R6 fresh window times out");
        clear(2'b11);

        // Twisted-pair mode
        tp_sel = 1'b1;
        link_fail = 1'b0;
        frame(6);
        bits(60);
        expect_flags(0, 0, "R7 twisted-pair link up");
        link_fail = 1'b1;
        frame(6);
        expect_flags(1, 1, "R8 twisted-pair link fail");
        clear(2'b11);
        expect_flags(0, 0, "R10 clear after link fail");
        link_fail = 1'b0;
        tp_sel = 1'b0;

        // Set and clear in the same cycle
        frame(2);
        bits(WIN - 1);
        bit_en = 1'b1; clr_stb = 1'b1; clr_mask = 2'b11; tick();
        bit_en = 1'b0; clr_stb = 1'b0; clr_mask = 2'b00; tick();
        expect_flags(1, 1, "R11 set wins over clear");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule